// File: doc/BRIEF.md
# Multi-Channel DAC Register Front End

This block is the digital register interface for up to four 12-bit voltage-output DAC channels. It sits on a simple 32-bit memory-mapped bus with an address, a write strobe, write data, a read strobe and read data. For each channel it keeps a control word and a holding register. Toward the analog side it drives a 12-bit conversion code, a 2-bit range select and an output enable.

Each channel picks its own update source. In core-clock mode a code written over the bus reaches the converter on the next clock edge. In timer mode the write only fills the holding register, and the converter code is loaded from that register when a single-cycle `timer_tick_i` pulse arrives. An active-low clear bit in the control word zeroes the holding register and the converter code at once, and keeps them at zero while it stays low. The resistor string, the reference switching and the output buffer belong to the analog macro and are not part of this block.

Top module: `dac_regif`

## Requirements
- R1: After reset every control word reads 0x00 and every data word reads 0x00000000. Every `dac_code_o` field is 0, every `dac_range_o` field is 00 and every `dac_oe_o` bit is 0.
- R2: Channel n's control word is at byte address 0x600 + 8·n and its data word is at 0x604 + 8·n. Read data appears on `rd_data_o` on the clock edge after the cycle with `rd_en_i` high, and `rd_data_o` is 0 after any cycle without a read.
- R3: Control bits [1:0] drive that channel's `dac_range_o` field (00 power-down, 01 external reference, 10 internal 2.5 V, 11 analog supply). The channel's `dac_oe_o` bit is 0 exactly when those bits are 00.
- R4: Control bit 4 is an active-low clear. A control write with bit 4 = 0 zeroes the holding register and `dac_code_o` on that same edge. While bit 4 stays 0, writes to the data word are ignored.
- R5: When control bit 5 = 0 (core-clock mode) and bit 4 = 1, a data write puts bits [27:16] of the write data on `dac_code_o` at the write's clock edge.
- R6: When control bit 5 = 1 (timer mode), a data write changes only the holding register. `dac_code_o` loads the holding register's value from before the edge on any edge where `timer_tick_i` is high, and holds its value otherwise. If a write and a tick fall in the same cycle, the code takes the older value.
- R7: A data-word read returns the holding register in bits [27:16], with bits [31:28] and [15:0] set to zero.
- R8: Control bits [7:6], [3:2] and [31:8] are ignored on write and read back as zero.
- R9: An access to an address that maps to no register reads 0 and has no effect on any channel. This includes addresses outside 0x600..0x61F and addresses that are not 4-byte aligned.
- R10: Channels are independent. An access to one channel and a tick in core-clock mode change no other state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| timer_tick_i | input | 1 | Single-cycle timer event |
| dac_code_o | output | 48 | Code per channel, channel n at [12n+11:12n] |
| dac_range_o | output | 8 | Range select per channel, channel n at [2n+1:2n] |
| dac_oe_o | output | 4 | Output enable per channel, 0 = power-down |

## Verification
Every result is due one clock edge after its stimulus. Read data appears on the edge after the read strobe. A core-mode code appears on the write's edge, a timer-mode code on the tick's edge, and a clear takes effect on the control write's edge. Range and enable follow the control word on its write edge. The bench drives each cycle's inputs on the falling edge, updates its reference model at the next rising edge, and compares every output one nanosecond later. Each check therefore looks at exactly the edge where its result is due.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int CODE_W  = 12;
  localparam int DAT_LSB = 16;
  localparam int WORD_W  = 32;

  typedef struct packed {
    logic       upd_tmr;  // 1: code loads on timer tick
    logic       run;      // 0: channel held clear
    logic [1:0] rng;      // 00 = power-down
  } dac_ctrl_t;

  function automatic dac_ctrl_t word_to_ctrl(logic [7:0] w);
    return '{upd_tmr: w[5], run: w[4], rng: w[1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_to_word(dac_ctrl_t c);
    return {26'b0, c.upd_tmr, c.run, 2'b00, c.rng};
  endfunction
endpackage

// File: rtl/dac_addr_dec.sv
module dac_addr_dec #(
  parameter int N_CH      = 4,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [N_CH-1:0]   ctrl_sel_o,
  output logic [N_CH-1:0]   dat_sel_o
);
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(8 * N_CH);

  logic [ADDR_W-1:0] offs;
  logic [CH_W-1:0]   ch_idx;

  assign offs   = addr_i - BASE;
  assign ch_idx = offs[3 +: CH_W];
  assign hit_o  = (addr_i >= BASE) && (offs < SPAN) && (offs[1:0] == 2'b00);

  for (genvar g = 0; g < N_CH; g++) begin : g_sel
    assign ctrl_sel_o[g] = hit_o && (ch_idx == CH_W'(g)) && !offs[2];
    assign dat_sel_o[g]  = hit_o && (ch_idx == CH_W'(g)) &&  offs[2];
  end

  p_unmapped_nosel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ctrl_sel_o == '0) && (dat_sel_o == '0));
  p_sel_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_sel_o, dat_sel_o}));
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              dat_we_i,
  input  dac_ctrl_t         wr_ctrl_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              tick_i,
  output dac_ctrl_t         ctrl_o,
  output logic [CODE_W-1:0] hold_o,
  output logic [CODE_W-1:0] code_o
);
  dac_ctrl_t         ctrl_q, ctrl_d;
  logic [CODE_W-1:0] hold_q, hold_d, code_q, code_d;
  logic              clr;

  always_comb begin
    ctrl_d = ctrl_we_i ? wr_ctrl_i : ctrl_q;
    clr    = !ctrl_d.run;  // clear acts on the control write's own edge
    if (clr)           hold_d = '0;
    else if (dat_we_i) hold_d = wr_code_i;
    else               hold_d = hold_q;
    if (clr)                 code_d = '0;
    else if (!ctrl_q.upd_tmr) code_d = hold_d;
    else if (tick_i)          code_d = hold_q;
    else                      code_d = code_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      hold_q <= '0;
      code_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      hold_q <= hold_d;
      code_q <= code_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign hold_o = hold_q;
  assign code_o = code_q;

  p_clr_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.run |-> (hold_q == '0) && (code_q == '0));
  p_core_upd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run && !ctrl_q.upd_tmr && dat_we_i && !ctrl_we_i |=> code_q == $past(wr_code_i));
  p_tmr_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run && ctrl_q.upd_tmr && !tick_i && !ctrl_we_i |=> $stable(code_q));
  p_tmr_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run && ctrl_q.upd_tmr && tick_i && !ctrl_we_i |=> code_q == $past(hold_q));
endmodule

// File: rtl/dac_regif.sv
module dac_regif
  import dac_pkg::*;
#(
  parameter int N_CH      = 4,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h600
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_en_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  input  logic                     rd_en_i,
  output logic [WORD_W-1:0]        rd_data_o,
  input  logic                     timer_tick_i,
  output logic [N_CH*CODE_W-1:0]   dac_code_o,
  output logic [N_CH*2-1:0]        dac_range_o,
  output logic [N_CH-1:0]          dac_oe_o
);
  logic              hit;
  logic [N_CH-1:0]   ctrl_sel, dat_sel;
  logic [WORD_W-1:0] ch_word [N_CH];
  logic [WORD_W-1:0] rd_word, rd_q;
  dac_ctrl_t         wr_ctrl;
  logic [CODE_W-1:0] wr_code;
  logic              unused_wdata;

  assign wr_ctrl      = word_to_ctrl(wr_data_i[7:0]);
  assign wr_code      = wr_data_i[DAT_LSB +: CODE_W];
  assign unused_wdata = ^{wr_data_i[31:28], wr_data_i[15:8], wr_data_i[3:2]};

  dac_addr_dec #(.N_CH(N_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .hit_o      (hit),
    .ctrl_sel_o (ctrl_sel),
    .dat_sel_o  (dat_sel)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dac_ctrl_t         ctrl;
    logic [CODE_W-1:0] hold;
    logic [CODE_W-1:0] code;

    dac_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (wr_en_i && ctrl_sel[g]),
      .dat_we_i  (wr_en_i && dat_sel[g]),
      .wr_ctrl_i (wr_ctrl),
      .wr_code_i (wr_code),
      .tick_i    (timer_tick_i),
      .ctrl_o    (ctrl),
      .hold_o    (hold),
      .code_o    (code)
    );

    assign dac_code_o[g*CODE_W +: CODE_W] = code;
    assign dac_range_o[g*2 +: 2]          = ctrl.rng;
    assign dac_oe_o[g]                    = (ctrl.rng != 2'b00);
    assign ch_word[g] = ctrl_sel[g] ? ctrl_to_word(ctrl) :
                        dat_sel[g]  ? {{(WORD_W-DAT_LSB-CODE_W){1'b0}}, hold, {DAT_LSB{1'b0}}} :
                                      '0;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_CH; i++) rd_word = rd_word | ch_word[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_word;
    else              rd_q <= '0;
  end

  assign rd_data_o = rd_q;

  p_rd_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rd_data_o == '0);
  p_rd_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> rd_data_o == '0);
  p_rsvd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && hit && (ctrl_sel != '0) |=> rd_data_o[31:6] == '0 && rd_data_o[3:2] == 2'b00);
endmodule

// File: tb/sim_dac_regif.sv
module sim_dac_regif;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0, re = 1'b0, tick = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [47:0] code;
  logic [7:0]  rng;
  logic [3:0]  oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  m_ctrl [NC];
  logic [11:0] m_hold [NC];
  logic [11:0] m_code [NC];
  logic [31:0] exp_rd;

  always #2 clk = ~clk;

  dac_regif u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
    .rd_en_i(re), .rd_data_o(rd), .timer_tick_i(tick),
    .dac_code_o(code), .dac_range_o(rng), .dac_oe_o(oe)
  );

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit mapped(input logic [11:0] a);
    return a >= 12'h600 && a < 12'h620 && a[1:0] == 2'b00;
  endfunction

  task automatic check_outs(input string tag);
    check({tag, " rd_data"}, rd === exp_rd, rd, exp_rd);
    for (int c = 0; c < NC; c++) begin
      check({tag, " code"}, code[c*12 +: 12] === m_code[c], 32'(code[c*12 +: 12]), 32'(m_code[c]));
      check({tag, " range R3"}, rng[c*2 +: 2] === m_ctrl[c][1:0], 32'(rng[c*2 +: 2]), 32'(m_ctrl[c][1:0]));
      check({tag, " oe R3"}, oe[c] === (m_ctrl[c][1:0] != 2'b00), 32'(oe[c]), 32'(m_ctrl[c][1:0] != 2'b00));
    end
  endtask

  task automatic model(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input logic r, input logic t);
    bit hit = mapped(a);
    int ch = int'((a - 12'h600) >> 3);
    bit isd = a[2];
    exp_rd = '0;
    if (r && hit) exp_rd = isd ? {4'b0, m_hold[ch], 16'b0} : {24'b0, m_ctrl[ch]};
    for (int c = 0; c < NC; c++) begin
      logic [7:0]  oc = m_ctrl[c], nc = m_ctrl[c];
      logic [11:0] nh = m_hold[c], ncode = m_code[c];
      if (w && hit && ch == c && !isd) nc = d[7:0] & 8'h33;
      if (w && hit && ch == c && isd && oc[4]) nh = d[27:16];
      if (!nc[4]) begin nh = '0; ncode = '0; end
      else if (!oc[5]) ncode = nh;
      else if (t) ncode = m_hold[c];
      m_ctrl[c] = nc; m_hold[c] = nh; m_code[c] = ncode;
    end
  endtask

  task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                     input logic r, input logic t, input string tag);
    @(negedge clk);
    addr = a; we = w; wd = d; re = r; tick = t;
    @(posedge clk);
    model(a, w, d, r, t);
    #1;
    check_outs(tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(a, 1'b1, d, 1'b0, 1'b0, tag);
  endtask

  task automatic rdc(input logic [11:0] a, input string tag);
    cyc(a, 1'b0, '0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin m_ctrl[c] = '0; m_hold[c] = '0; m_code[c] = '0; end
    exp_rd = '0;
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge clk);
    #1;
    check_outs("R1 reset");
    rst_n = 1'b1;
    rdc(12'h600, "R1 ctrl0 reset read");
    rdc(12'h61C, "R1 data3 reset read");
    // data write while cleared is ignored
    wr(12'h604, 32'h0FFF_0000, "R4 write while clear");
    rdc(12'h604, "R4 hold still zero");
    // reserved control bits dropped
    wr(12'h600, 32'hFFFF_FFDD, "R8 ctrl write");
    rdc(12'h600, "R8 ctrl readback");
    check("R8 reserved read zero", rd === 32'h11, rd, 32'h11);
    // core-clock mode
    wr(12'h604, 32'hFABC_DEFF, "R5 core write");
    check("R5 code at write edge", code[11:0] === 12'hABC, 32'(code[11:0]), 32'hABC);
    rdc(12'h604, "R7 data readback");
    check("R7 field position", rd === 32'h0ABC_0000, rd, 32'h0ABC_0000);
    cyc(12'h000, 1'b0, '0, 1'b0, 1'b1, "R10 tick in core mode");
    // timer mode
    wr(12'h600, 32'h0000_0032, "R6 to timer mode");
    wr(12'h604, 32'h0123_0000, "R6 write holds");
    check("R6 code stalls", code[11:0] === 12'hABC, 32'(code[11:0]), 32'hABC);
    cyc(12'h000, 1'b0, '0, 1'b0, 1'b1, "R6 tick");
    check("R6 tick loads", code[11:0] === 12'h123, 32'(code[11:0]), 32'h123);
    wr(12'h604, 32'h0777_0000, "R6 second write");
    cyc(12'h604, 1'b1, 32'h0456_0000, 1'b0, 1'b1, "R6 write with tick");
    check("R6 old value wins", code[11:0] === 12'h777, 32'(code[11:0]), 32'h777);
    // clear
    wr(12'h600, 32'h0000_0020, "R4 clear");
    check("R4 clear same edge", code[11:0] === 12'h000, 32'(code[11:0]), 32'h0);
    check("R3 oe off", oe[0] === 1'b0, 32'(oe[0]), 32'h0);
    rdc(12'h604, "R4 hold cleared");
    // unmapped accesses
    wr(12'h608, 32'h0000_0013, "R10 ctrl1");
    wr(12'h60C, 32'h0555_0000, "R10 data1");
    wr(12'h620, 32'hFFFF_FFFF, "R9 write past end");
    wr(12'h60E, 32'h0AAA_0000, "R9 unaligned write");
    wr(12'h5FC, 32'h0000_0000, "R9 write below base");
    rdc(12'h620, "R9 read past end");
    rdc(12'h60A, "R9 read unaligned");
    rdc(12'h60C, "R9 data1 kept");
    check("R9 data1 value", rd === 32'h0555_0000, rd, 32'h0555_0000);
    // randomized mix
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [31:0] d = $urandom;
      bit w, r;
      if ($urandom_range(9) < 8) a = 12'h600 + 12'($urandom_range(NC-1) * 8) + ($urandom_range(1) ? 12'h4 : 12'h0);
      else a = 12'($urandom);
      if (!a[2] && $urandom_range(3) != 0) d[4] = 1'b1;
      w = ($urandom_range(2) == 0);
      r = !w && ($urandom_range(1) == 0);
      cyc(a, w, d, r, ($urandom_range(4) == 0), "R10 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule